// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides when a timer/counter may advance. It turns a 3-bit source code into a one-cycle count-enable strobe, all on the single system clock. The code can stop the timer, let it advance on every cycle, or slow it through one of four fixed prescaler ratios drawn from a shared free-running divider. It can also make the timer count transitions of an external pin, with the code choosing which edge polarity counts.

The pin level is always sampled, whatever direction the pin has elsewhere in the chip. Firmware that drives the pin as an output can therefore step the counter by toggling the pin. The counter, the waveform logic and the register interface sit outside this block. The strobe is registered and clean, so a change of source code never produces a stray or doubled pulse.

Top module: `tmr_src_sel`

## Requirements
- R1: Source code 3'b000 stops the timer. `cnt_en` stays low on every cycle whose preceding edge saw this code.
- R2: Source code 3'b001 asserts `cnt_en` on every cycle, one cycle after the code is applied.
- R3: Source codes 3'b010, 3'b011, 3'b100 and 3'b101 assert `cnt_en` once every 8, 64, 256 and 1024 cycles. Over any window that is a multiple of 1024 cycles, the counts are exactly the window divided by the ratio.
- R4: Source code 3'b110 asserts `cnt_en` once for each falling edge of `ext_pin`. Rising edges produce nothing.
- R5: Source code 3'b111 asserts `cnt_en` once for each rising edge of `ext_pin`. Falling edges produce nothing.
- R6: A pin edge passes through a two-stage synchronizer and an edge detector. `cnt_en` goes high on the third rising clock edge after the pin changes and stays high for exactly one cycle.
- R7: A new source code takes effect at the next clock edge. Switching never produces an extra or doubled strobe.
- R8: Synchronous reset clears `cnt_en` and the prescaler. With code 3'b010 held, the first strobe appears eight clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 3 | Count source code |
| ext_pin | input | 1 | Raw external pin level, asynchronous |
| cnt_en | output | 1 | One-cycle count-enable strobe |

## Verification
The bench builds the block with its default parameters: divider tap widths of 3, 6, 8 and 10 bits and a two-stage synchronizer. These values make 1024 cycles the full prescaler period. A 2048-cycle counting window therefore covers two whole periods, so every code has an exact expected strobe count whatever the divider phase is when the window opens. The two-stage synchronizer fixes the pin-to-strobe latency at three edges, which the edge tests sample cycle by cycle.

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int TAP_LG0  = 3,
  parameter int TAP_LG1  = 6,
  parameter int TAP_LG2  = 8,
  parameter int TAP_LG3  = 10,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] src_sel,
  input  logic       ext_pin,
  output logic       cnt_en
);
  localparam int PRE_W = TAP_LG3;

  function automatic int tap_lg(input int i);
    case (i)
      0:       return TAP_LG0;
      1:       return TAP_LG1;
      2:       return TAP_LG2;
      default: return TAP_LG3;
    endcase
  endfunction

  logic [PRE_W-1:0]  pre_q;
  logic [3:0]        tap;
  logic [SYNC_LEN:0] pin_sh;
  logic              pin_now, pin_old, edge_rise, edge_fall;
  logic              hit;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < 4; i++) begin : g_tap
    assign tap[i] = &pre_q[tap_lg(i)-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) pin_sh <= '0;
    else     pin_sh <= {pin_sh[SYNC_LEN-1:0], ext_pin};
  end

  assign pin_now   = pin_sh[SYNC_LEN-1];
  assign pin_old   = pin_sh[SYNC_LEN];
  assign edge_rise = pin_now & ~pin_old;
  assign edge_fall = ~pin_now & pin_old;

  always_comb begin
    case (src_sel)
      3'b001:  hit = 1'b1;
      3'b010:  hit = tap[0];
      3'b011:  hit = tap[1];
      3'b100:  hit = tap[2];
      3'b101:  hit = tap[3];
      3'b110:  hit = edge_fall;
      3'b111:  hit = edge_rise;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_en <= 1'b0;
    else     cnt_en <= hit;
  end

  a_r1_stopped: assert property (@(posedge clk) disable iff (rst)
    ($past(src_sel) == 3'b000) |-> !cnt_en);

  a_r2_every_cycle: assert property (@(posedge clk) disable iff (rst)
    ($past(src_sel) == 3'b001 && !$past(rst)) |-> cnt_en);

  a_r3_div8_phase: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && $past(src_sel) == 3'b010) |-> (pre_q[TAP_LG0-1:0] == '0));

  a_r3_div1024_phase: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && $past(src_sel) == 3'b101) |-> (pre_q == '0));

  a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && $past(src_sel) == 3'b111 && src_sel == 3'b111) |=> !cnt_en);

  a_r6_fall_single: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && $past(src_sel) == 3'b110 && src_sel == 3'b110) |=> !cnt_en);
endmodule

// File: tb/tmr_src_sel_tb.sv
module tmr_src_sel_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] src_sel = 3'b000;
  logic       ext_pin = 1'b0;
  logic       cnt_en;
  int         n_chk = 0;
  int         n_fail = 0;
  int         cyc = 0;

  always #4 clk = ~clk;

  tmr_src_sel u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .ext_pin(ext_pin), .cnt_en(cnt_en)
  );

  localparam int NV = 8;
  localparam logic [2:0] SEL_V [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam int         EXP_V [NV] = '{0, 2048, 256, 32, 8, 2, 0, 0};
  localparam int WIN = 2048;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_win(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (cnt_en) c++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <= 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    int first;
    step(3);
    check("R8 reset output", int'(cnt_en), 0);
    src_sel = 3'b010;
    rst = 1'b0;
    first = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (cnt_en && first == 0) first = k;
    end
    check("R8 first div8 strobe edge", first, 8);

    for (int v = 0; v < NV; v++) begin
      src_sel = SEL_V[v];
      step(2);
      count_win(WIN, c);
      case (v)
        0:       check("R1 stopped count", c, EXP_V[v]);
        1:       check("R2 undivided count", c, EXP_V[v]);
        6, 7:    check("R4/R5 static pin count", c, EXP_V[v]);
        default: check("R3 prescaled count", c, EXP_V[v]);
      endcase
    end

    src_sel = 3'b110; ext_pin = 1'b0; step(6);
    ext_pin = 1'b1;
    count_win(10, c);
    check("R4 rising ignored on falling code", c, 0);
    ext_pin = 1'b0;
    step(1); check("R6 latency edge1", int'(cnt_en), 0);
    step(1); check("R6 latency edge2", int'(cnt_en), 0);
    step(1); check("R6 strobe edge3", int'(cnt_en), 1);
    step(1); check("R6 one cycle wide", int'(cnt_en), 0);
    count_win(10, c);
    check("R4 single falling strobe", c, 0);

    src_sel = 3'b111; step(6);
    ext_pin = 1'b1;
    count_win(10, c);
    check("R5 single rising strobe", c, 1);
    ext_pin = 1'b0;
    count_win(10, c);
    check("R5 falling ignored on rising code", c, 0);

    ext_pin = 1'b1;
    step(1); ext_pin = 1'b0;
    count_win(12, c);
    check("R5 short pulse one strobe", c, 1);

    src_sel = 3'b001; step(3);
    check("R7 running before switch", int'(cnt_en), 1);
    src_sel = 3'b000;
    step(1); check("R7 stop next edge", int'(cnt_en), 0);
    count_win(20, c);
    check("R1 stays stopped", c, 0);
    src_sel = 3'b001;
    step(1); check("R7 start next edge", int'(cnt_en), 1);

    src_sel = 3'b101; step(2);
    count_win(1024, c);
    src_sel = 3'b100;
    begin
      int c2;
      count_win(1024, c2);
      check("R7 no doubled strobe across switch", c + c2, 5);
    end

    rst = 1'b1; src_sel = 3'b001;
    step(2);
    check("R8 reset clears strobe", int'(cnt_en), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule